// File: doc/BRIEF.md
# Supply Supervisor Mode Sequencer with Guarded Watchdog Disable

This block sequences the operating modes of a supply supervisor that serves a host microcontroller. After power-up it waits in a configuration mode, the request mode, for a timed window. If the host configures it in time it moves on to the running mode. If not, it drives a reset pulse of fixed length and opens a fresh window. It decodes 8-bit register writes from an upstream serial byte interface. Bits [7:4] carry the register address and bits [3:0] carry the data.

The block can also disable the watchdog, which is useful while software is brought up. This needs a strict run of three writes, made back to back, inside the first configuration window after power-up, and only while the power-loss flag is still unread. Once unlocked, the host can move between the run, standby and stop debug modes. A wake from stop debug opens another timed window. In that window the host must choose a debug mode again, or a reset follows.

The window length and the reset pulse length are parameters in clock cycles. The window defaults to 350 ms at 100 MHz.

Top module: `sup_mode_ctrl`

## Requirements
- R1: While and after `rst_ni` is low (power-up), `mode_o` is 0 (request), `bfail_o` is 1, `rst_o` is 0 and `wdog_en_o` is 1.
- R2: If no write arrives, the block stays in request mode for exactly WIN_CYC cycles. It then enters reset mode (code 2), where `rst_o` is high for exactly RST_CYC cycles, and then returns to request mode with a fresh window.
- R3: A write to the timer register (address 4'h3) in request mode moves `mode_o` to 1 (running) in the next cycle. Mode codes: 0 request, 1 running, 2 reset, 3 run-debug, 4 standby-debug, 5 stop-debug.
- R4: With `bfail_o` set, the writes 8'h3x, then 8'h10, then 8'h1?101 (bit 3 ignored), made back to back and completed within WIN_CYC cycles of entering request mode, select run-debug (3) with `wdog_en_o` low.
- R5: If the unlock run has begun (the timer write, or the timer write and 8'h10) and the window ends before it completes, the block enters reset mode.
- R6: Any other write in the middle of the unlock run abandons it. The block stays in running mode with `wdog_en_o` high, a later 8'h15 has no effect, and no reset is raised when the window ends.
- R7: A pulse on `rd_mode_i` (read of the mode register) clears `bfail_o` until the next power-up. With the flag clear, the unlock run leaves the block in running mode with the watchdog enabled.
- R8: In any debug mode other than stop, a write of 8'h10 returns the block to running mode (1) with `wdog_en_o` high.
- R9: In run-debug or standby-debug, a mode register write with data[2:0]=101 selects run-debug, 100 selects standby-debug, and 110 selects stop-debug. The watchdog stays disabled in all three.
- R10: In stop-debug, `wake_i` moves the block to request mode. A mode register write with data[2:0] of 101 or 100 within WIN_CYC cycles re-enters run-debug or standby-debug. Otherwise the window ends in reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; release marks power-up |
| wr_valid_i | input | 1 | One-cycle strobe for a register write |
| wr_byte_i | input | 8 | Write byte: [7:4] address, [3:0] data |
| rd_mode_i | input | 1 | One-cycle strobe for a mode register read (clears the power-loss flag) |
| wake_i | input | 1 | Wake event from stop-debug |
| mode_o | output | 3 | Current mode code |
| rst_o | output | 1 | Reset pulse to the host |
| wdog_en_o | output | 1 | Watchdog enable |
| bfail_o | output | 1 | Power-loss flag |

## Verification
The bench goes after the exact window edges. A timer that is off by one shows up as a request phase or a reset pulse that is one cycle too long or too short. It checks that a half-finished unlock run ends in reset; a design that treats the run like plain configuration would stay in running mode. It checks that a stray write breaks the run; a design that only matches the final byte would unlock anyway. It also checks that reading the flag bars debug entry, and that a wake from stop-debug without a timely mode write ends in reset rather than in a silent return to debug.

// File: rtl/sup_mode_pkg.sv
package sup_mode_pkg;
  typedef enum logic [2:0] {
    MODE_NREQ     = 3'd0,
    MODE_NORM     = 3'd1,
    MODE_RST      = 3'd2,
    MODE_DBG_RUN  = 3'd3,
    MODE_DBG_STBY = 3'd4,
    MODE_DBG_STOP = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TIM  = 2'd1,
    SEQ_ARM  = 2'd2
  } seq_e;

  localparam logic [3:0] ADDR_MODE = 4'h1;
  localparam logic [3:0] ADDR_TIM  = 4'h3;

  typedef struct packed {
    logic any;
    logic tim;
    logic m_zero;
    logic m_run;
    logic m_stby;
    logic m_stop;
  } cmd_t;
endpackage

// File: rtl/sup_cmd_decode.sv
module sup_cmd_decode
  import sup_mode_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  logic [3:0] addr, data;
  logic       is_mode;

  assign addr    = byte_i[7:4];
  assign data    = byte_i[3:0];
  assign is_mode = valid_i && (addr == ADDR_MODE);

  always_comb begin
    cmd_o        = '0;
    cmd_o.any    = valid_i;
    cmd_o.tim    = valid_i && (addr == ADDR_TIM);
    cmd_o.m_zero = is_mode && (data == 4'h0);
    // bit 3 of the data is a don't-care for mode selection
    cmd_o.m_run  = is_mode && (data[2:0] == 3'b101);
    cmd_o.m_stby = is_mode && (data[2:0] == 3'b100);
    cmd_o.m_stop = is_mode && (data[2:0] == 3'b110);
  end
endmodule

// File: rtl/sup_cycle_timer.sv
module sup_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign done_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/sup_mode_ctrl.sv
module sup_mode_ctrl
  import sup_mode_pkg::*;
#(
  parameter int unsigned WIN_CYC = 35_000_000,
  parameter int unsigned RST_CYC = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_byte_i,
  input  logic       rd_mode_i,
  input  logic       wake_i,
  output logic [2:0] mode_o,
  output logic       rst_o,
  output logic       wdog_en_o,
  output logic       bfail_o
);
  mode_e state_q, state_d;
  seq_e  seq_q, seq_d;
  logic  wake_q, wake_d;
  logic  bfail_q;
  cmd_t  cmd;
  logic  win_en, win_done, rst_done, in_rst;

  sup_cmd_decode u_dec (
    .valid_i(wr_valid_i),
    .byte_i (wr_byte_i),
    .cmd_o  (cmd)
  );

  // window runs in request mode and while an unlock run is pending
  assign win_en = (state_q == MODE_NREQ) || (state_q == MODE_NORM && seq_q != SEQ_IDLE);
  assign in_rst = (state_q == MODE_RST);

  sup_cycle_timer #(.LIMIT(WIN_CYC)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!win_en),
    .en_i  (win_en),
    .done_o(win_done)
  );

  sup_cycle_timer #(.LIMIT(RST_CYC)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_rst),
    .en_i  (in_rst),
    .done_o(rst_done)
  );

  always_comb begin
    state_d = state_q;
    seq_d   = seq_q;
    wake_d  = wake_q;
    unique case (state_q)
      MODE_NREQ: begin
        if (cmd.tim) begin
          state_d = MODE_NORM;
          seq_d   = (bfail_q && !wake_q) ? SEQ_TIM : SEQ_IDLE;
          wake_d  = 1'b0;
        end else if (wake_q && cmd.m_run) begin
          state_d = MODE_DBG_RUN;
          wake_d  = 1'b0;
        end else if (wake_q && cmd.m_stby) begin
          state_d = MODE_DBG_STBY;
          wake_d  = 1'b0;
        end else if (win_done) begin
          state_d = MODE_RST;
          seq_d   = SEQ_IDLE;
          wake_d  = 1'b0;
        end
      end
      MODE_NORM: begin
        if (cmd.any) begin
          if (seq_q == SEQ_TIM && bfail_q && cmd.m_zero) begin
            seq_d = SEQ_ARM;
          end else if (seq_q == SEQ_ARM && bfail_q && cmd.m_run) begin
            state_d = MODE_DBG_RUN;
            seq_d   = SEQ_IDLE;
          end else begin
            seq_d = SEQ_IDLE;
          end
        end else if (win_done) begin
          state_d = MODE_RST;
          seq_d   = SEQ_IDLE;
        end
      end
      MODE_RST: begin
        if (rst_done) state_d = MODE_NREQ;
      end
      MODE_DBG_RUN, MODE_DBG_STBY: begin
        if (cmd.m_zero)      state_d = MODE_NORM;
        else if (cmd.m_run)  state_d = MODE_DBG_RUN;
        else if (cmd.m_stby) state_d = MODE_DBG_STBY;
        else if (cmd.m_stop) state_d = MODE_DBG_STOP;
      end
      MODE_DBG_STOP: begin
        if (wake_i) begin
          state_d = MODE_NREQ;
          wake_d  = 1'b1;
        end
      end
      default: state_d = MODE_NREQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_NREQ;
      seq_q   <= SEQ_IDLE;
      wake_q  <= 1'b0;
      bfail_q <= 1'b1;
    end else begin
      state_q <= state_d;
      seq_q   <= seq_d;
      wake_q  <= wake_d;
      if (rd_mode_i) bfail_q <= 1'b0;
    end
  end

  assign mode_o    = state_q;
  assign rst_o     = in_rst;
  assign wdog_en_o = !(state_q inside {MODE_DBG_RUN, MODE_DBG_STBY, MODE_DBG_STOP});
  assign bfail_o   = bfail_q;
endmodule

// File: rtl/sup_mode_chk.sv
module sup_mode_chk #(
  parameter int unsigned RST_CYC = 100
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic [7:0] wr_byte_i,
  input logic       rd_mode_i,
  input logic       wake_i,
  input logic [2:0] mode_o,
  input logic       rst_o,
  input logic       wdog_en_o,
  input logic       bfail_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= '0;
    else if (rst_o) run_q <= run_q + 1;
    else            run_q <= '0;
  end

  p_rst_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> (run_q < RST_CYC));

  p_rst_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> ($past(run_q) == RST_CYC - 1));

  p_rst_to_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd2 && mode_o != 3'd2) |-> (mode_o == 3'd0));

  p_req_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd0 && mode_o == 3'd1) |-> $past(wr_valid_i && wr_byte_i[7:4] == 4'h3));

  p_unlock_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd1 && mode_o == 3'd3) |-> ($past(bfail_o) && !wdog_en_o));

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bfail_o |=> !bfail_o);

  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode_i |=> !bfail_o);

  p_dbg_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd3 && mode_o == 3'd1) |-> ($past(wr_valid_i && wr_byte_i == 8'h10) && wdog_en_o));

  p_stop_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd5 && mode_o != 3'd5) |-> (mode_o == 3'd0 && $past(wake_i)));
endmodule

bind sup_mode_ctrl sup_mode_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_byte_i (wr_byte_i),
  .rd_mode_i (rd_mode_i),
  .wake_i    (wake_i),
  .mode_o    (mode_o),
  .rst_o     (rst_o),
  .wdog_en_o (wdog_en_o),
  .bfail_o   (bfail_o)
);

// File: tb/sup_mode_ctrl_tb.sv
module sup_mode_ctrl_tb;
  localparam int WIN = 20;
  localparam int RST = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_byte_i = 8'h00;
  logic       rd_mode_i = 1'b0;
  logic       wake_i = 1'b0;
  logic [2:0] mode_o;
  logic       rst_o, wdog_en_o, bfail_o;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  sup_mode_ctrl #(.WIN_CYC(WIN), .RST_CYC(RST)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_byte_i(wr_byte_i),
    .rd_mode_i(rd_mode_i), .wake_i(wake_i), .mode_o(mode_o), .rst_o(rst_o),
    .wdog_en_o(wdog_en_o), .bfail_o(bfail_o)
  );

  always #5 clk_i = ~clk_i;

  // behavioural reference model
  int m_mode = 0, m_seq = 0, m_cnt = 0, m_rcnt = 0;
  bit m_wk = 0, m_bf = 1;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_seq = 0; m_cnt = 0; m_rcnt = 0; m_wk = 0; m_bf = 1;
    end else begin
      int a, d, nm, ns;
      bit tmo, rdone, en, nw;
      a = int'(wr_byte_i[7:4]);
      d = int'(wr_byte_i[3:0]);
      en = (m_mode == 0) || (m_mode == 1 && m_seq != 0);
      tmo = en && (m_cnt == WIN - 1);
      rdone = (m_mode == 2) && (m_rcnt == RST - 1);
      nm = m_mode; ns = m_seq; nw = m_wk;
      case (m_mode)
        0: begin
          if (wr_valid_i && a == 3) begin nm = 1; ns = (m_bf && !m_wk) ? 1 : 0; nw = 0; end
          else if (wr_valid_i && m_wk && a == 1 && (d % 8) == 5) begin nm = 3; nw = 0; end
          else if (wr_valid_i && m_wk && a == 1 && (d % 8) == 4) begin nm = 4; nw = 0; end
          else if (tmo) begin nm = 2; nw = 0; ns = 0; end
        end
        1: begin
          if (wr_valid_i) begin
            if (m_seq == 1 && m_bf && a == 1 && d == 0) ns = 2;
            else if (m_seq == 2 && m_bf && a == 1 && (d % 8) == 5) begin nm = 3; ns = 0; end
            else ns = 0;
          end else if (tmo) begin nm = 2; ns = 0; end
        end
        2: if (rdone) nm = 0;
        3, 4: if (wr_valid_i && a == 1) begin
          if (d == 0) nm = 1;
          else if ((d % 8) == 5) nm = 3;
          else if ((d % 8) == 4) nm = 4;
          else if ((d % 8) == 6) nm = 5;
        end
        5: if (wake_i) begin nm = 0; nw = 1; end
        default: ;
      endcase
      m_cnt = en ? m_cnt + 1 : 0;
      m_rcnt = (m_mode == 2) ? m_rcnt + 1 : 0;
      if (rd_mode_i) m_bf = 0;
      m_mode = nm; m_seq = ns; m_wk = nw;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk({phase, " model mode"}, int'(mode_o), m_mode);
      chk({phase, " model rst"}, int'(rst_o), (m_mode == 2) ? 1 : 0);
      chk({phase, " model wdog"}, int'(wdog_en_o), (m_mode >= 3) ? 0 : 1);
      chk({phase, " model bfail"}, int'(bfail_o), int'(m_bf));
    end
  end

  task automatic wr(input logic [7:0] b);
    wr_valid_i = 1'b1; wr_byte_i = b;
    @(negedge clk_i);
    wr_valid_i = 1'b0; wr_byte_i = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic power_cycle();
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_mode(input int target, input int limit, output int n);
    n = 0;
    while (int'(mode_o) != target && n < limit) begin n++; @(negedge clk_i); end
  endtask

  initial begin
    int n;
    bit saw_rst;
    idle(3);
    phase = "R1";
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 bfail", int'(bfail_o), 1);
    chk("R1 rst", int'(rst_o), 0);
    chk("R1 wdog", int'(wdog_en_o), 1);
    rst_ni = 1'b1;

    phase = "R2";
    n = 0;
    while (mode_o == 3'd0 && n < 1000) begin n++; @(negedge clk_i); end
    chk("R2 request length", n, WIN);
    chk("R2 reset mode", int'(mode_o), 2);
    n = 0;
    while (rst_o && n < 1000) begin n++; @(negedge clk_i); end
    chk("R2 reset pulse length", n, RST);
    chk("R2 back to request", int'(mode_o), 0);

    phase = "R3";
    power_cycle();
    wr(8'h30);
    chk("R3 running after timer write", int'(mode_o), 1);
    phase = "R4";
    wr(8'h10);
    chk("R4 armed still running", int'(mode_o), 1);
    wr(8'h15);
    chk("R4 run-debug", int'(mode_o), 3);
    chk("R4 watchdog off", int'(wdog_en_o), 0);

    phase = "R9";
    wr(8'h14);
    chk("R9 standby-debug", int'(mode_o), 4);
    wr(8'h1D);
    chk("R9 run-debug bit3 ignored", int'(mode_o), 3);
    wr(8'h16);
    chk("R9 stop-debug", int'(mode_o), 5);
    chk("R9 watchdog off in stop", int'(wdog_en_o), 0);

    phase = "R10";
    wake_i = 1'b1; @(negedge clk_i); wake_i = 1'b0;
    chk("R10 wake to request", int'(mode_o), 0);
    idle(5);
    wr(8'h1C);
    chk("R10 standby-debug after wake", int'(mode_o), 4);
    wr(8'h16);
    wake_i = 1'b1; @(negedge clk_i); wake_i = 1'b0;
    wait_mode(2, WIN + 5, n);
    chk("R10 late after wake gives reset", int'(mode_o), 2);
    chk("R10 wake window length", n, WIN);
    wait_mode(0, RST + 5, n);

    phase = "R8";
    power_cycle();
    wr(8'h30); wr(8'h10); wr(8'h15);
    chk("R8 debug entered", int'(mode_o), 3);
    wr(8'h10);
    chk("R8 leave debug", int'(mode_o), 1);
    chk("R8 watchdog back on", int'(wdog_en_o), 1);

    phase = "R5";
    power_cycle();
    wr(8'h30);
    wait_mode(2, WIN + 5, n);
    chk("R5 timer-only run times out", int'(mode_o), 2);
    power_cycle();
    wr(8'h30); wr(8'h10);
    wait_mode(2, WIN + 5, n);
    chk("R5 armed run times out", int'(mode_o), 2);
    chk("R5 rst asserted", int'(rst_o), 1);

    phase = "R6";
    power_cycle();
    wr(8'h30); wr(8'h35); wr(8'h10); wr(8'h15);
    chk("R6 broken run stays running", int'(mode_o), 1);
    chk("R6 watchdog on", int'(wdog_en_o), 1);
    saw_rst = 0;
    for (int i = 0; i < 3 * WIN; i++) begin
      if (rst_o) saw_rst = 1;
      @(negedge clk_i);
    end
    chk("R6 no reset after window", int'(saw_rst), 0);
    chk("R6 still running", int'(mode_o), 1);

    phase = "R7";
    power_cycle();
    rd_mode_i = 1'b1; @(negedge clk_i); rd_mode_i = 1'b0;
    chk("R7 flag cleared", int'(bfail_o), 0);
    wr(8'h30); wr(8'h10); wr(8'h15);
    chk("R7 no debug after read", int'(mode_o), 1);
    chk("R7 watchdog on", int'(wdog_en_o), 1);
    idle(2 * WIN);
    chk("R7 flag stays clear", int'(bfail_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule